// File: doc/BRIEF.md
# Split-Operand Recursive Unsigned Multiplier

This block multiplies two unsigned operands of width 2b and returns a 4b-bit product. It does this by cutting each operand into an upper and a lower half of b bits. From these halves it forms four half-width products: upper×upper, upper×lower, lower×upper and lower×lower. The upper×upper and lower×lower products land in bit fields that do not overlap, so they are joined side by side into one operand. The two cross products are added at bit offset b. The whole addition is three operands wide, and every adder in it is a b-bit slice. Carries pass from one slice to the next.

A parameter sets how many times the split is applied: zero, one or two levels. With zero levels the block is a plain full-width product. With two levels, each half-width product is itself built from four quarter-width products. The default is b = 8, which gives a 16×16 multiplier with one level of recursion.

The caller pulses `start` with both operands present on the same cycle. On the next cycle `valid` is high for exactly one cycle and the registered product is on `product`. A new `start` may be given on every cycle.

Top module: `dnc_mult_top`

## Requirements
- R1: While `rst` is high at a clock edge, `valid` and `product` are cleared to zero on that edge. This holds even when `start` is high in the same cycle.
- R2: When `start` is high at a clock edge, `product` equals `op_a × op_b` (unsigned, 4b bits, no truncation) on the next cycle.
- R3: `valid` is high in exactly those cycles that follow a cycle with `start` high, and low otherwise.
- R4: While `start` is low, changes on `op_a` and `op_b` have no effect: `product` keeps its last value.
- R5: All-ones operands give the largest product, (2^2b − 1)^2. For 16-bit operands this is 0xFFFE0001.
- R6: A zero in either operand gives a zero product.
- R7: Operands with only their upper halves nonzero give a product that lies wholly in the upper-by-upper field, at bit offset 2b.
- R8: One operand with only its upper half nonzero and the other with only its lower half nonzero exercise a cross product alone. The result appears at bit offset b.
- R9: Starts on consecutive cycles each produce their own product on consecutive cycles. `valid` stays high throughout.
- R10: The top b-bit adder slice of every combining stage never produces a carry out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the operands and multiply them |
| op_a | input | 2b | Multiplicand, unsigned |
| op_b | input | 2b | Multiplier, unsigned |
| valid | output | 1 | High for one cycle when `product` holds a new result |
| product | output | 4b | Registered unsigned product |

## Verification
A `start` can fall in the same cycle that `valid` presents the previous result. The bench provokes this with a run of back-to-back starts using distinct operands. Each result must match its own operands, one cycle later, with `valid` never dropping. A reset can also coincide with a `start`. The bench raises both together and requires `valid` and `product` to read zero on the next cycle, so reset wins over the capture.

// File: rtl/dnc_pkg.sv
package dnc_pkg;
  // Legal recursion depth bounds
  localparam int unsigned MAX_LEVELS = 2;

  // Smallest width that may be split again; keeps every slice at least 2 bits wide
  localparam int unsigned MIN_SPLIT_W = 4;

  function automatic bit can_split(input int unsigned width, input int unsigned depth);
    return (depth > 0) && (width >= MIN_SPLIT_W) && ((width % 2) == 0);
  endfunction
endpackage

// File: rtl/dnc_slice_add.sv
module dnc_slice_add #(
  parameter int unsigned SW = 8
) (
  input  logic [SW-1:0] x,
  input  logic [SW-1:0] y,
  input  logic          cin,
  output logic [SW-1:0] s,
  output logic          cout
);
  // One narrow ripple slice; all accumulation is built from these
  assign {cout, s} = {1'b0, x} + {1'b0, y} + {{SW{1'b0}}, cin};
endmodule

// File: rtl/dnc_combine.sv
module dnc_combine #(
  parameter int unsigned H = 8
) (
  input  logic [2*H-1:0] pp_hh,
  input  logic [2*H-1:0] pp_hl,
  input  logic [2*H-1:0] pp_lh,
  input  logic [2*H-1:0] pp_ll,
  output logic [4*H-1:0] sum
);
  localparam int unsigned UPW = 3 * H;

  // Stage 1: the two cross products, two slices
  logic [2:0]     xc;
  logic [2*H-1:0] xs;
  assign xc[0] = 1'b0;

  for (genvar i = 0; i < 2; i++) begin : g_cross
    dnc_slice_add #(.SW(H)) u_slc (
      .x   (pp_hl[i*H +: H]),
      .y   (pp_lh[i*H +: H]),
      .cin (xc[i]),
      .s   (xs[i*H +: H]),
      .cout(xc[i+1])
    );
  end

  // Stage 2: the joined hh|ll term above offset H, plus the cross sum, three slices
  logic [UPW-1:0] joined_up;
  logic [UPW-1:0] cross_ext;
  logic [UPW-1:0] up_sum;
  logic [3:0]     uc;

  assign joined_up = {pp_hh, pp_ll[2*H-1:H]};
  assign cross_ext = {{(H-1){1'b0}}, xc[2], xs};
  assign uc[0]     = 1'b0;

  for (genvar j = 0; j < 3; j++) begin : g_upper
    dnc_slice_add #(.SW(H)) u_slc (
      .x   (joined_up[j*H +: H]),
      .y   (cross_ext[j*H +: H]),
      .cin (uc[j]),
      .s   (up_sum[j*H +: H]),
      .cout(uc[j+1])
    );
  end

  assign sum = {up_sum, pp_ll[H-1:0]};

  // R10: a 2H x 2H product fits 4H bits, so the top slice must not carry out
  always_comb begin
    p_no_top_carry_r10: assert (uc[3] !== 1'b1)
      else $error("R10 carry out of top combining slice");
  end
endmodule

// File: rtl/dnc_rec_mult.sv
module dnc_rec_mult #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 1
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  import dnc_pkg::*;

  localparam int unsigned H = W / 2;

  if (can_split(W, DEPTH)) begin : g_split
    logic [W-1:0] p_hh, p_hl, p_lh, p_ll;

    dnc_rec_mult #(.W(H), .DEPTH(DEPTH-1)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(p_hh));
    dnc_rec_mult #(.W(H), .DEPTH(DEPTH-1)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(p_hl));
    dnc_rec_mult #(.W(H), .DEPTH(DEPTH-1)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(p_lh));
    dnc_rec_mult #(.W(H), .DEPTH(DEPTH-1)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));

    dnc_combine #(.H(H)) u_comb (
      .pp_hh(p_hh),
      .pp_hl(p_hl),
      .pp_lh(p_lh),
      .pp_ll(p_ll),
      .sum  (p)
    );
  end else begin : g_base
    // Behavioural base product
    assign p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  end
endmodule

// File: rtl/dnc_mult_top.sv
module dnc_mult_top #(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned LEVELS = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [2*HALF_W-1:0]   op_a,
  input  logic [2*HALF_W-1:0]   op_b,
  output logic                  valid,
  output logic [4*HALF_W-1:0]   product
);
  localparam int unsigned OPW  = 2 * HALF_W;
  localparam int unsigned PRW  = 2 * OPW;
  localparam int unsigned DEPW = (LEVELS > dnc_pkg::MAX_LEVELS) ? dnc_pkg::MAX_LEVELS : LEVELS;

  logic [PRW-1:0] comb_prod;

  dnc_rec_mult #(.W(OPW), .DEPTH(DEPW)) u_core (
    .a(op_a),
    .b(op_b),
    .p(comb_prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      product <= '0;
    end else begin
      valid <= start;
      if (start) product <= comb_prod;
    end
  end

  p_valid_after_start_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> valid);

  p_no_spurious_valid_r3: assert property (@(posedge clk) disable iff (rst)
    !start |=> !valid);

  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(product));

  p_product_exact_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (product == ({{OPW{1'b0}}, $past(op_a)} * {{OPW{1'b0}}, $past(op_b)})));
endmodule

// File: tb/dnc_mult_top_tb_top.sv
module dnc_mult_top_tb_top;
  localparam int unsigned HB  = 8;
  localparam int unsigned OPW = 2 * HB;
  localparam int unsigned PRW = 4 * HB;

  logic           clk = 1'b0;
  logic           rst;
  logic           start;
  logic [OPW-1:0] op_a, op_b;
  logic           valid;
  logic [PRW-1:0] product;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dnc_mult_top #(.HALF_W(HB), .LEVELS(1)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .op_a(op_a), .op_b(op_b), .valid(valid), .product(product)
  );

  function automatic logic [PRW-1:0] ref_mul(input logic [OPW-1:0] x, input logic [OPW-1:0] y);
    logic [PRW-1:0] acc = '0;
    for (int i = 0; i < OPW; i++)
      if (y[i]) acc = acc + ({{OPW{1'b0}}, x} << i);
    return acc;
  endfunction

  task automatic check(input string req, input logic [PRW-1:0] act, input logic [PRW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic one_mult(input string req, input logic [OPW-1:0] x, input logic [OPW-1:0] y);
    start = 1'b1; op_a = x; op_b = y;
    @(negedge clk);
    start = 1'b0;
    check({req, " valid"}, {{(PRW-1){1'b0}}, valid}, 1);
    check(req, product, ref_mul(x, y));
    @(negedge clk);
  endtask

  task automatic t_reset_r1();
    rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {{(PRW-1){1'b0}}, valid}, 0);
    check("R1 reset product", product, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_basic_r2();
    one_mult("R2 mixed", 16'h1234, 16'h5678);
    one_mult("R2 odd", 16'h00A7, 16'h3C01);
    one_mult("R2 wide", 16'hBEEF, 16'h0F0F);
  endtask

  task automatic t_valid_r3();
    start = 1'b0;
    @(negedge clk);
    check("R3 valid low idle", {{(PRW-1){1'b0}}, valid}, 0);
    one_mult("R3 single pulse", 16'h0003, 16'h0005);
    check("R3 valid drops", {{(PRW-1){1'b0}}, valid}, 0);
  endtask

  task automatic t_ignore_r4();
    logic [PRW-1:0] held;
    one_mult("R4 setup", 16'h00FF, 16'h0101);
    held = ref_mul(16'h00FF, 16'h0101);
    op_a = 16'hFFFF; op_b = 16'h7777;
    @(negedge clk);
    op_a = 16'h1111;
    @(negedge clk);
    check("R4 product held", product, held);
    check("R4 no valid", {{(PRW-1){1'b0}}, valid}, 0);
  endtask

  task automatic t_corners();
    one_mult("R5 all ones", 16'hFFFF, 16'hFFFF);
    check("R5 literal", product, 32'hFFFE0001);
    one_mult("R6 zero a", 16'h0000, 16'hABCD);
    one_mult("R6 zero b", 16'h9876, 16'h0000);
    one_mult("R7 high only", 16'hFF00, 16'hFF00);
    check("R7 literal", product, 32'hFE010000);
    one_mult("R8 cross", 16'hFF00, 16'h00FF);
    check("R8 literal", product, 32'h00FE0100);
    one_mult("R10 top slice", 16'hFFFF, 16'hFF01);
  endtask

  task automatic t_back_to_back_r9();
    logic [OPW-1:0] xa [4];
    logic [OPW-1:0] xb [4];
    xa = '{16'h0001, 16'hFFFF, 16'h8000, 16'h4321};
    xb = '{16'hFFFF, 16'h0002, 16'h8000, 16'h1234};
    for (int k = 0; k < 4; k++) begin
      start = 1'b1; op_a = xa[k]; op_b = xb[k];
      @(negedge clk);
      check("R9 valid stays", {{(PRW-1){1'b0}}, valid}, 1);
      check("R9 own result", product, ref_mul(xa[k], xb[k]));
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_wins_r1();
    one_mult("R1 pre", 16'h0ABC, 16'h0DEF);
    rst = 1'b1; start = 1'b1; op_a = 16'h1357; op_b = 16'h2468;
    @(negedge clk);
    check("R1 reset beats start valid", {{(PRW-1){1'b0}}, valid}, 0);
    check("R1 reset beats start product", product, 0);
    rst = 1'b0; start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset_r1();
    t_basic_r2();
    t_valid_r3();
    t_ignore_r4();
    t_corners();
    t_back_to_back_r9();
    t_reset_wins_r1();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule